// File: doc/BRIEF.md
# Sliced VBI ancillary packet formatter

This block turns the bytes sliced from one vertical-blanking line into a self-describing ancillary packet. A line is announced with a one-cycle start strobe. The strobe carries the line number, the field, a 4-bit line mode, two match flags, an error flag and the number of payload bytes. The payload bytes then arrive, one per accepted cycle. The block holds them in a line buffer and waits for the next horizontal blanking interval. It then emits the finished packet one byte per cycle on a stream output. At the same time it writes the same bytes into a 512-byte FIFO, which a reader drains at its own pace.

A packet has a fixed layout. It starts with a preamble. Next come three parity-protected header bytes: a data identifier, the line mode and a 32-bit word count. Two bytes follow that carry the line number and the flags. After them come the payload, a 6-bit checksum and zero fill up to a 4-byte boundary. If the FIFO has no room for the whole packet, the FIFO copy is dropped in full and a sticky overflow flag is raised. The stream copy is still sent.

Top module: `vbi_anc_packer`

## Requirements
- R1: Bytes 0, 1 and 2 of every packet are 00h, FFh and FFh.
- R2: In bytes 3, 4 and 5, bit 6 is the XOR of bits 5:0 (even parity) and bit 7 is its inverse.
- R3: Byte 3 is 91h for field_sel=0 with line_num<24, 53h for field_sel=0 with line_num>=24, 55h for field_sel=1 with line_num<24, and 97h for field_sel=1 with line_num>=24.
- R4: Byte 4 bits 5:0 are {00b, mode_code}. Byte 5 bits 5:0 are L/4-2, where L is the packet length in bytes.
- R5: Byte 6 is line_num[7:0]. Byte 7 is {000b, edc_err, match1, match2, line_num[9:8]}, with edc_err in bit 4, match1 in bit 3 and match2 in bit 2.
- R6: Bytes 8 to 7+N are the N payload bytes in arrival order. Byte 8+N is {00b, S}, where S is the low 6 bits of the sum of bytes 3 through 7+N.
- R7: The bytes after the checksum are 00h. L is the smallest multiple of 4 that is at least 9+N.
- R8: out_valid stays low until all N payload bytes have been taken. After that, the first rising clock edge that sees hblank high starts the packet. out_valid is then high for exactly L consecutive cycles, one byte per cycle.
- R9: Each packet that is kept appears in the FIFO in stream order. fifo_data shows the oldest byte without a read. A cycle with fifo_rd high and fifo_empty low removes that byte. fifo_level counts the stored bytes.
- R10: When the FIFO's free space is smaller than L at the start of a packet, no byte of that packet is stored and overflow goes high and stays high. The stream copy is still sent.
- R11: After reset, out_valid=0, fifo_level=0, fifo_empty=1, fifo_full=0 and overflow=0.
- R12: fifo_full is high exactly when fifo_level equals 512, and a packet that fits exactly is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle strobe that latches the line descriptor below |
| line_num | input | 10 | Video line number |
| field_sel | input | 1 | 0 = first field, 1 = second field |
| mode_code | input | 4 | Line mode code placed in byte 4 |
| match1 | input | 1 | Match flag 1 |
| match2 | input | 1 | Match flag 2 |
| edc_err | input | 1 | Error flag from the error detection logic |
| byte_count | input | 6 | Number of payload bytes N (0 to 48) |
| din_valid | input | 1 | Payload byte strobe |
| din | input | 8 | Payload byte |
| hblank | input | 1 | Horizontal blanking window, which releases a waiting packet |
| out_valid | output | 1 | Stream byte valid |
| out_byte | output | 8 | Stream byte |
| fifo_rd | input | 1 | Remove the oldest FIFO byte |
| fifo_data | output | 8 | Oldest FIFO byte (show-ahead) |
| fifo_level | output | 10 | Number of bytes stored |
| fifo_empty | output | 1 | FIFO holds no byte |
| fifo_full | output | 1 | FIFO holds 512 bytes |
| overflow | output | 1 | Sticky flag: a packet was refused by the FIFO |

## Verification
The block registers the start strobe and each payload byte, so the line is held one edge after the last byte is driven. The bench then keeps hblank low for a chosen gap and expects out_valid low throughout. It raises hblank and reads byte k of the packet at the falling edge k+1 cycles later. The FIFO write for each byte lands on the same edge that moves the stream to the next byte. For that reason fifo_level, fifo_full and overflow are compared one falling edge after the last stream byte. The show-ahead fifo_data is compared at the falling edge before each read edge.

// File: rtl/vbi_anc_pkg.sv
package vbi_anc_pkg;

    // Configuration
    localparam int MAX_BYTES  = 48;   // largest payload of one line
    localparam int FIFO_DEPTH = 512;  // bytes held in the packet FIFO
    localparam int LATE_LINE  = 24;   // first line that uses the late-line identifiers
    localparam int LINE_W     = 10;
    localparam int MODE_W     = 4;
    localparam int HDR_BYTES  = 8;    // preamble + ids + internal ids

    // Derived
    localparam int NB_W    = $clog2(MAX_BYTES + 1);
    localparam int PKT_MAX = ((MAX_BYTES + HDR_BYTES + 1 + 3) / 4) * 4;
    localparam int IDX_W   = $clog2(PKT_MAX + 1);
    localparam int LVL_W   = $clog2(FIFO_DEPTH + 1);

    localparam logic [7:0] PRE_LOW  = 8'h00;
    localparam logic [7:0] PRE_HIGH = 8'hFF;
    localparam logic [7:0] FILL_VAL = 8'h00;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic              field;
        logic [MODE_W-1:0] mode;
        logic              match1;
        logic              match2;
        logic              err;
        logic [NB_W-1:0]   nbytes;
    } line_info_t;

    typedef enum logic [1:0] {
        CAP_IDLE,
        CAP_FILL,
        CAP_HOLD
    } cap_state_e;

    typedef enum logic {
        EM_WAIT,
        EM_SEND
    } em_state_e;

    // Six value bits topped with even parity and its inverse
    function automatic logic [7:0] guard_byte(input logic [5:0] v);
        logic ev;
        ev = ^v;
        return {~ev, ev, v};
    endfunction

    // Identifier value bits: field picks 15h/17h over 11h/13h, late picks 13h/17h
    function automatic logic [5:0] did_bits(input logic field, input logic late);
        return {3'b010, field, late, 1'b1};
    endfunction

    function automatic logic [IDX_W-1:0] pkt_len(input logic [NB_W-1:0] n);
        int t;
        t = ((int'(n) + HDR_BYTES + 1 + 3) / 4) * 4;
        return IDX_W'(t);
    endfunction

    function automatic logic [5:0] word_count(input logic [NB_W-1:0] n);
        return 6'(int'(pkt_len(n)) / 4 - 2);
    endfunction

    function automatic logic is_late(input logic [LINE_W-1:0] line);
        return line >= LINE_W'(LATE_LINE);
    endfunction

    function automatic logic [7:0] id_hi_byte(input line_info_t i);
        return {3'b000, i.err, i.match1, i.match2, i.line[9:8]};
    endfunction

    function automatic logic [7:0] id_byte(input line_info_t i);
        return guard_byte(did_bits(i.field, is_late(i.line)));
    endfunction

    function automatic logic [7:0] mode_byte(input line_info_t i);
        return guard_byte({2'b00, i.mode});
    endfunction

    function automatic logic [7:0] count_byte(input line_info_t i);
        return guard_byte(word_count(i.nbytes));
    endfunction

    // Checksum contribution of bytes 3..7, modulo 64
    function automatic logic [5:0] hdr_sum(input line_info_t i);
        logic [5:0] s;
        s = id_byte(i)[5:0] + mode_byte(i)[5:0] + count_byte(i)[5:0]
          + i.line[5:0] + id_hi_byte(i)[5:0];
        return s;
    endfunction

endpackage

// File: rtl/vbi_capture.sv
module vbi_capture
    import vbi_anc_pkg::*;
#(
    parameter int SLOTS = MAX_BYTES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  line_info_t       info_in,
    input  logic             din_valid,
    input  logic [7:0]       din,
    input  logic             release_i,
    input  logic [NB_W-1:0]  rd_idx,
    output logic             ready_o,
    output line_info_t       info_o,
    output logic [5:0]       sum_o,
    output logic [7:0]       rd_byte
);

    cap_state_e      state;
    line_info_t      info;
    logic [NB_W-1:0] cnt;
    logic [5:0]      sum;
    logic [7:0]      slot [SLOTS];
    logic            take;

    assign take = (state == CAP_FILL) && din_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CAP_IDLE;
            info  <= '0;
            cnt   <= '0;
            sum   <= '0;
        end else begin
            unique case (state)
                CAP_IDLE: begin
                    if (start) begin
                        info  <= info_in;
                        sum   <= hdr_sum(info_in);
                        cnt   <= '0;
                        state <= (info_in.nbytes == '0) ? CAP_HOLD : CAP_FILL;
                    end
                end
                CAP_FILL: begin
                    if (din_valid) begin
                        sum <= sum + din[5:0];
                        cnt <= cnt + NB_W'(1);
                        if (cnt == info.nbytes - NB_W'(1)) state <= CAP_HOLD;
                    end
                end
                CAP_HOLD: begin
                    if (release_i) state <= CAP_IDLE;
                end
                default: state <= CAP_IDLE;
            endcase
        end
    end

    // One register per payload slot, written when the fill counter points at it
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (take && cnt == NB_W'(g)) slot[g] <= din;
        end
    end

    assign ready_o = (state == CAP_HOLD);
    assign info_o  = info;
    assign sum_o   = sum;
    assign rd_byte = slot[rd_idx];

    // R6: the fill counter never passes the announced count
    a_r6_fill_bound: assert property (@(posedge clk) disable iff (rst)
        (state == CAP_FILL) |-> (cnt < info.nbytes));

    // R8: the emitter only releases a line that is fully held
    a_r8_release_held: assert property (@(posedge clk) disable iff (rst)
        release_i |-> (state == CAP_HOLD));

endmodule

// File: rtl/vbi_emit.sv
module vbi_emit
    import vbi_anc_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ready_i,
    input  logic              hblank,
    input  line_info_t        info,
    input  logic [5:0]        sum,
    input  logic [7:0]        data_byte,
    input  logic [LVL_W-1:0]  fifo_level,
    output logic [NB_W-1:0]   data_idx,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    output logic              wr_en,
    output logic              done_o,
    output logic              ovf_o
);

    em_state_e        state;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] len;
    logic [IDX_W-1:0] cs_pos;
    logic [LVL_W-1:0] room;
    logic             room_short;
    logic             drop;
    logic             ovf;
    logic             last;
    logic [7:0]       sel;

    assign len        = pkt_len(info.nbytes);
    assign cs_pos     = IDX_W'(HDR_BYTES) + IDX_W'(info.nbytes);
    assign room       = LVL_W'(DEPTH) - fifo_level;
    assign room_short = room < LVL_W'(len);
    assign last       = (idx == len - IDX_W'(1));
    assign data_idx   = NB_W'(idx - IDX_W'(HDR_BYTES));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= EM_WAIT;
            idx   <= '0;
            drop  <= 1'b0;
            ovf   <= 1'b0;
        end else begin
            unique case (state)
                EM_WAIT: begin
                    if (ready_i && hblank) begin
                        state <= EM_SEND;
                        idx   <= '0;
                        drop  <= room_short;
                        if (room_short) ovf <= 1'b1;
                    end
                end
                EM_SEND: begin
                    if (last) state <= EM_WAIT;
                    else      idx   <= idx + IDX_W'(1);
                end
                default: state <= EM_WAIT;
            endcase
        end
    end

    always_comb begin
        if (idx < IDX_W'(HDR_BYTES)) begin
            unique case (idx[2:0])
                3'd0:    sel = PRE_LOW;
                3'd1:    sel = PRE_HIGH;
                3'd2:    sel = PRE_HIGH;
                3'd3:    sel = id_byte(info);
                3'd4:    sel = mode_byte(info);
                3'd5:    sel = count_byte(info);
                3'd6:    sel = info.line[7:0];
                default: sel = id_hi_byte(info);
            endcase
        end else if (idx < cs_pos) begin
            sel = data_byte;
        end else if (idx == cs_pos) begin
            sel = {2'b00, sum};
        end else begin
            sel = FILL_VAL;
        end
    end

    assign out_valid = (state == EM_SEND);
    assign out_byte  = sel;
    assign wr_en     = (state == EM_SEND) && !drop;
    assign done_o    = (state == EM_SEND) && last;
    assign ovf_o     = ovf;

    // Checker-only run length of the current stream burst
    logic [IDX_W:0] run_len;
    always_ff @(posedge clk) begin
        if (rst)            run_len <= '0;
        else if (out_valid) run_len <= run_len + (IDX_W+1)'(1);
        else                run_len <= '0;
    end

    // R1: a burst opens with the zero preamble byte
    a_r1_preamble_head: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (out_byte == 8'h00));

    // R2: protected header bytes carry consistent parity bits
    a_r2_guard_bits: assert property (@(posedge clk) disable iff (rst)
        (out_valid && idx >= IDX_W'(3) && idx <= IDX_W'(5))
            |-> (out_byte[6] == ^out_byte[5:0]) && (out_byte[7] != out_byte[6]));

    // R7: every burst is a whole number of 32-bit words
    a_r7_word_multiple: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> (run_len[1:0] == 2'b00));

    // R8: a packet is sent only while its line is held complete
    a_r8_send_needs_line: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ready_i);

    // R10: the overflow flag never clears without reset
    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o);

endmodule

// File: rtl/vbi_byte_fifo.sv
module vbi_byte_fifo
    import vbi_anc_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    output logic [LVL_W-1:0] level,
    output logic             empty,
    output logic             full
);

    localparam int ADDR_W = $clog2(DEPTH);

    logic [7:0]        mem [DEPTH];
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] rd_ptr;
    logic              wr_ok;
    logic              rd_ok;

    assign full  = (level == LVL_W'(DEPTH));
    assign empty = (level == '0);
    assign wr_ok = wr_en && !full;
    assign rd_ok = rd_en && !empty;

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr + ADDR_W'(1);
            if (rd_ok) rd_ptr <= rd_ptr + ADDR_W'(1);
            unique case ({wr_ok, rd_ok})
                2'b10:   level <= level + LVL_W'(1);
                2'b01:   level <= level - LVL_W'(1);
                default: level <= level;
            endcase
        end
    end

    assign rd_data = mem[rd_ptr];

    // R12: the level never goes past the depth
    a_r12_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

    // R10: the room check upstream keeps writes away from a full FIFO
    a_r10_no_write_full: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full);

    // R9: a lone read lowers the level by one
    a_r9_read_step: assert property (@(posedge clk) disable iff (rst)
        (rd_ok && !wr_ok) |=> (level == $past(level) - LVL_W'(1)));

endmodule

// File: rtl/vbi_anc_packer.sv
module vbi_anc_packer
    import vbi_anc_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    parameter int SLOTS = MAX_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    input  logic              field_sel,
    input  logic [MODE_W-1:0] mode_code,
    input  logic              match1,
    input  logic              match2,
    input  logic              edc_err,
    input  logic [NB_W-1:0]   byte_count,
    input  logic              din_valid,
    input  logic [7:0]        din,
    input  logic              hblank,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    input  logic              fifo_rd,
    output logic [7:0]        fifo_data,
    output logic [LVL_W-1:0]  fifo_level,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              overflow
);

    line_info_t      info_in;
    line_info_t      info_held;
    logic            line_ready;
    logic            line_done;
    logic [5:0]      csum;
    logic [NB_W-1:0] data_idx;
    logic [7:0]      data_byte;
    logic            wr_en;

    always_comb begin
        info_in.line   = line_num;
        info_in.field  = field_sel;
        info_in.mode   = mode_code;
        info_in.match1 = match1;
        info_in.match2 = match2;
        info_in.err    = edc_err;
        info_in.nbytes = byte_count;
    end

    vbi_capture #(.SLOTS(SLOTS)) u_capture (
        .clk       (clk),
        .rst       (rst),
        .start     (line_start),
        .info_in   (info_in),
        .din_valid (din_valid),
        .din       (din),
        .release_i (line_done),
        .rd_idx    (data_idx),
        .ready_o   (line_ready),
        .info_o    (info_held),
        .sum_o     (csum),
        .rd_byte   (data_byte)
    );

    vbi_emit #(.DEPTH(DEPTH)) u_emit (
        .clk        (clk),
        .rst        (rst),
        .ready_i    (line_ready),
        .hblank     (hblank),
        .info       (info_held),
        .sum        (csum),
        .data_byte  (data_byte),
        .fifo_level (fifo_level),
        .data_idx   (data_idx),
        .out_valid  (out_valid),
        .out_byte   (out_byte),
        .wr_en      (wr_en),
        .done_o     (line_done),
        .ovf_o      (overflow)
    );

    vbi_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (out_byte),
        .rd_en   (fifo_rd),
        .rd_data (fifo_data),
        .level   (fifo_level),
        .empty   (fifo_empty),
        .full    (fifo_full)
    );

endmodule

// File: tb/vbi_anc_packer_bench.sv
module vbi_anc_packer_bench;
    import vbi_anc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int QDEPTH     = 512;

    logic        clk = 1'b0;
    logic        rst;
    logic        line_start;
    logic [9:0]  line_num;
    logic        field_sel;
    logic [3:0]  mode_code;
    logic        match1, match2, edc_err;
    logic [5:0]  byte_count;
    logic        din_valid;
    logic [7:0]  din;
    logic        hblank;
    logic        out_valid;
    logic [7:0]  out_byte;
    logic        fifo_rd;
    logic [7:0]  fifo_data;
    logic [9:0]  fifo_level;
    logic        fifo_empty, fifo_full, overflow;

    always #(CLK_PERIOD/2) clk = ~clk;

    vbi_anc_packer u_vbi_anc_packer (
        .clk(clk), .rst(rst), .line_start(line_start), .line_num(line_num),
        .field_sel(field_sel), .mode_code(mode_code), .match1(match1),
        .match2(match2), .edc_err(edc_err), .byte_count(byte_count),
        .din_valid(din_valid), .din(din), .hblank(hblank),
        .out_valid(out_valid), .out_byte(out_byte), .fifo_rd(fifo_rd),
        .fifo_data(fifo_data), .fifo_level(fifo_level), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .overflow(overflow)
    );

    int         tests = 0;
    int         fails = 0;
    logic [7:0] pdata   [64];
    logic [7:0] exp_pkt [64];
    int         exp_len;
    logic [7:0] mq [$];
    int         exp_ovf = 0;

    task automatic chk(input string tag, input int act, input int expv);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] pbyte(input logic [5:0] v);
        logic e;
        e = ^v;
        return {~e, e, v};
    endfunction

    function automatic string tag_of(input int i, input int n);
        if (i < 3)       return "R1 preamble";
        if (i == 3)      return "R3 data id";
        if (i < 6)       return "R4 mode/count";
        if (i < 8)       return "R5 internal id";
        if (i <= 8 + n)  return "R6 payload/checksum";
        return "R7 fill";
    endfunction

    task automatic build_expect(input logic [9:0] ln, input logic fld, input logic [3:0] md,
                                input logic m1, input logic m2, input logic er, input int n);
        int s;
        exp_len = ((9 + n + 3) / 4) * 4;
        exp_pkt[0] = 8'h00;
        exp_pkt[1] = 8'hFF;
        exp_pkt[2] = 8'hFF;
        if (!fld) exp_pkt[3] = (ln >= 10'd24) ? 8'h53 : 8'h91;
        else      exp_pkt[3] = (ln >= 10'd24) ? 8'h97 : 8'h55;
        exp_pkt[4] = pbyte({2'b00, md});
        exp_pkt[5] = pbyte(6'(exp_len / 4 - 2));
        exp_pkt[6] = ln[7:0];
        exp_pkt[7] = {3'b000, er, m1, m2, ln[9:8]};
        for (int i = 0; i < n; i++) exp_pkt[8 + i] = pdata[i];
        s = 0;
        for (int i = 3; i < 8 + n; i++) s += int'(exp_pkt[i]);
        exp_pkt[8 + n] = {2'b00, 6'(s % 64)};
        for (int i = 9 + n; i < exp_len; i++) exp_pkt[i] = 8'h00;
    endtask

    // Drives one line, holds hblank low for gap cycles, then checks the packet
    task automatic run_packet(input logic [9:0] ln, input logic fld, input logic [3:0] md,
                              input logic m1, input logic m2, input logic er,
                              input int n, input int gap);
        for (int i = 0; i < n; i++) pdata[i] = 8'($urandom);
        build_expect(ln, fld, md, m1, m2, er, n);
        line_num = ln; field_sel = fld; mode_code = md;
        match1 = m1; match2 = m2; edc_err = er; byte_count = 6'(n);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            chk("R8 no output while filling", int'(out_valid), 0);
            din_valid = 1'b1;
            din = pdata[i];
            @(negedge clk);
        end
        din_valid = 1'b0;
        for (int w = 0; w < gap; w++) begin
            chk("R8 waits for hblank", int'(out_valid), 0);
            @(negedge clk);
        end
        hblank = 1'b1;
        @(negedge clk);
        for (int i = 0; i < exp_len; i++) begin
            chk("R8 valid during packet", int'(out_valid), 1);
            chk(tag_of(i, n), int'(out_byte), int'(exp_pkt[i]));
            if (i >= 3 && i <= 5)
                chk("R2 parity bits", int'(out_byte[7:6]),
                    int'({~(^out_byte[5:0]), ^out_byte[5:0]}));
            @(negedge clk);
        end
        hblank = 1'b0;
        chk("R8 valid ends after L bytes", int'(out_valid), 0);
        if (QDEPTH - mq.size() >= exp_len) begin
            for (int i = 0; i < exp_len; i++) mq.push_back(exp_pkt[i]);
        end else begin
            exp_ovf = 1;
        end
        chk("R10 overflow flag", int'(overflow), exp_ovf);
        chk("R9 fifo level", int'(fifo_level), mq.size());
        chk("R12 fifo full", int'(fifo_full), int'(mq.size() == QDEPTH));
    endtask

    task automatic drain(input int k);
        for (int i = 0; i < k; i++) begin
            chk("R9 not empty", int'(fifo_empty), 0);
            chk("R9 fifo data", int'(fifo_data), int'(mq[0]));
            fifo_rd = 1'b1;
            void'(mq.pop_front());
            @(negedge clk);
        end
        fifo_rd = 1'b0;
        chk("R9 level after read", int'(fifo_level), mq.size());
        chk("R9 empty flag", int'(fifo_empty), int'(mq.size() == 0));
    endtask

    initial begin
        #(CLK_PERIOD * 180000);
        tests++;
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0656));
        rst = 1'b1; line_start = 1'b0; line_num = '0; field_sel = 1'b0;
        mode_code = '0; match1 = 1'b0; match2 = 1'b0; edc_err = 1'b0;
        byte_count = '0; din_valid = 1'b0; din = '0; hblank = 1'b0; fifo_rd = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk("R11 out_valid", int'(out_valid), 0);
        chk("R11 level", int'(fifo_level), 0);
        chk("R11 empty", int'(fifo_empty), 1);
        chk("R11 full", int'(fifo_full), 0);
        chk("R11 overflow", int'(overflow), 0);

        // Directed: each identifier, empty and full payloads, flag positions
        run_packet(10'd10,  1'b0, 4'h7, 1'b0, 1'b0, 1'b0, 0, 3);
        run_packet(10'd24,  1'b1, 4'h3, 1'b1, 1'b0, 1'b0, 3, 0);
        run_packet(10'd300, 1'b0, 4'hC, 1'b0, 1'b1, 1'b0, 4, 5);
        run_packet(10'd23,  1'b1, 4'hF, 1'b1, 1'b1, 1'b1, 48, 1);
        run_packet(10'd23,  1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 1, 2);
        drain(mq.size());

        // Random lines with partial drains
        for (int k = 0; k < 24; k++) begin
            run_packet(10'($urandom), 1'($urandom), 4'($urandom), 1'($urandom),
                       1'($urandom), 1'($urandom), int'($urandom % 49), int'($urandom % 4));
            if ($urandom % 3 == 0) drain(int'($urandom % (mq.size() + 1)));
        end
        drain(mq.size());

        // R12 exact fill, then R10 refused packet
        for (int k = 0; k < 8; k++)
            run_packet(10'(6 + k), 1'b0, 4'h4, 1'b0, 1'b0, 1'b0, 48, 0);
        run_packet(10'd20, 1'b1, 4'h2, 1'b0, 1'b1, 1'b0, 20, 0);
        chk("R12 exact fit accepted", int'(fifo_level), 512);
        chk("R10 no overflow before refusal", int'(overflow), 0);
        run_packet(10'd15, 1'b0, 4'h1, 1'b1, 1'b0, 1'b0, 0, 1);
        chk("R10 level unchanged by refused packet", int'(fifo_level), 512);
        drain(mq.size());
        run_packet(10'd7, 1'b1, 4'h5, 1'b0, 1'b0, 1'b0, 5, 0);
        chk("R10 overflow stays set", int'(overflow), 1);
        drain(mq.size());

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule